// File: doc/BRIEF.md
# Transactional Region Nesting Controller

This block keeps track of nested transactional regions for a hardware transactional execution unit. Each begin event deepens the nesting and each end event makes it shallower. The fallback address given by the outermost begin is held so that a failed transaction can resume there. When the last end event closes the outermost region, the block asks the memory system for an atomic commit. It then waits until the commit is answered.

Three things send the block into its abort sequence: a commit that reports failure, an external abort input, or a begin that would push the nesting past its limit. The abort sequence asks for a register and memory rollback and waits for the rollback to finish. It then writes a status word meant for the accumulator, clears all transactional state and redirects the program counter to the saved fallback address.

The block also screens the end-transaction instruction. It raises an undefined-opcode fault when the transactional feature is switched off or an illegal prefix is present. It raises a general-protection fault when an end arrives outside any transaction.

Top module: `txn_nest_ctrl`

## Requirements
- R1: An end event is taken only when `endValid` is high and `endOpcode` equals 24'h0F01D5, with byte 0F in bits 23:16, 01 in bits 15:8 and D5 in bits 7:0. Any other opcode changes no state and raises no fault.
- R2: A taken end event raises `faultUd` for one cycle, in the cycle after it is sampled, in either of two cases: `featureWord[11]` is 0, or any bit of `endPrefixes` is set (bit 3 LOCK, bit 2 66h, bit 1 F2h, bit 0 F3h). This check takes priority over R3, and nesting depth and the active flag stay unchanged.
- R3: A taken end event that passes R2 while `active` is 0 raises `faultGp` for one cycle with `faultErrCode` equal to 0. No other state changes.
- R4: A begin event increments `nestDepth` and sets `active`. `beginFallback` is saved only when the depth was 0 beforehand.
- R5: A taken end event while active decrements `nestDepth`. `commitReq` rises only when the depth reaches 0.
- R6: `commitReq` stays high until `commitAck`. If `commitPass` is 1 at the acknowledge, `active` clears in the next cycle and no redirect occurs.
- R7: If `commitPass` is 0 at the commit acknowledge, the abort sequence starts with status cause 8'h02.
- R8: `abortValid` while active starts the abort sequence with cause 8'h01. `abortValid` while inactive is ignored.
- R9: A begin at depth MAX_DEPTH (default 7) does not raise the depth. It starts the abort sequence with cause 8'h04.
- R10: In the abort sequence, `rollbackReq` stays high until `rollbackAck`. In the cycle after the acknowledge, `statusValid` and `pcLoadValid` pulse, `statusWord[7:0]` holds the cause, `pcLoadAddr` holds the outermost fallback address, and depth and active are 0.
- R11: With `longMode` at 0, bits above 31 of `pcLoadAddr` are zero. With `longMode` at 1, the full saved address is driven.
- R12: Begin, end and abort inputs are ignored while a commit or rollback is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beginValid | input | 1 | Begin-transaction event |
| beginFallback | input | ADDR_W | Fallback address carried with the begin |
| endValid | input | 1 | Candidate end instruction |
| endOpcode | input | 24 | Opcode bytes of the candidate |
| endPrefixes | input | 4 | Prefix flags: LOCK, 66h, F2h, F3h |
| featureWord | input | 32 | Feature word; bit 11 enables transactions |
| abortValid | input | 1 | External abort condition |
| longMode | input | 1 | 1 selects the full-width program counter |
| commitReq | output | 1 | Atomic commit request |
| commitAck | input | 1 | Commit acknowledge |
| commitPass | input | 1 | Commit result, valid with the acknowledge |
| rollbackReq | output | 1 | Register and memory rollback request |
| rollbackAck | input | 1 | Rollback acknowledge |
| statusValid | output | 1 | Status word strobe |
| statusWord | output | 32 | Abort status for the accumulator |
| pcLoadValid | output | 1 | Program counter redirect strobe |
| pcLoadAddr | output | ADDR_W | Redirect target |
| faultUd | output | 1 | Undefined-opcode fault pulse |
| faultGp | output | 1 | General-protection fault pulse |
| faultErrCode | output | 16 | Error code for the protection fault |
| active | output | 1 | Transaction active flag |
| nestDepth | output | DEPTH_W | Current nesting depth |

## Verification
The hardest case to reach is the depth-overflow abort. It needs MAX_DEPTH begins with no end in between, followed by one more begin. The bench issues that chain of begins, giving each one a different fallback address, and confirms that the redirect goes to the first address and not a later one. A second hard case is an input arriving while a handshake is pending. To reach it, the bench holds back the rollback acknowledge for several cycles and drives a begin during that wait.

// File: rtl/txn_nest_pkg.sv
package txn_nest_pkg;
  typedef struct packed {
    logic incDepth;
    logic decDepth;
    logic latchFallback;
    logic clearAll;
  } dpStrobe_t;

  typedef enum logic [1:0] {ST_RUN, ST_COMMIT, ST_ROLLBACK} ctrlState_t;

  localparam logic [7:0]  CAUSE_EXT  = 8'h01;
  localparam logic [7:0]  CAUSE_FAIL = 8'h02;
  localparam logic [7:0]  CAUSE_NEST = 8'h04;
  localparam logic [23:0] END_OPCODE = 24'h0F01D5;
  localparam int          FEATURE_BIT = 11;
endpackage

// File: rtl/txn_nest_datapath.sv
module txn_nest_datapath
  import txn_nest_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int MAX_DEPTH = 7,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpStrobe_t          strb,
  input  logic [ADDR_W-1:0]  beginFallback,
  input  logic               longMode,
  output logic               activeQ,
  output logic [DEPTH_W-1:0] depthQ,
  output logic [ADDR_W-1:0]  pcTarget
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(MAX_DEPTH);

  logic [ADDR_W-1:0] fallbackQ;
  logic [ADDR_W-1:0] lowMask;

  generate
    if (ADDR_W > 32) begin : g_wide
      assign lowMask = {{(ADDR_W-32){1'b0}}, {32{1'b1}}};
    end else begin : g_narrow
      assign lowMask = '1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeQ   <= 1'b0;
      depthQ    <= '0;
      fallbackQ <= '0;
    end else begin
      if (strb.clearAll) begin
        activeQ <= 1'b0;
        depthQ  <= '0;
      end else if (strb.incDepth) begin
        activeQ <= 1'b1;
        depthQ  <= depthQ + 1'b1;
      end else if (strb.decDepth) begin
        depthQ  <= depthQ - 1'b1;
      end
      if (strb.latchFallback) fallbackQ <= beginFallback;
    end
  end

  assign pcTarget = longMode ? fallbackQ : (fallbackQ & lowMask);

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depthQ <= DEPTH_MAX);
  p_no_inc_at_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.incDepth |-> depthQ < DEPTH_MAX);
  p_latch_outer_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.latchFallback |-> depthQ == '0);
endmodule

// File: rtl/txn_nest_ctrl_fsm.sv
module txn_nest_ctrl_fsm
  import txn_nest_pkg::*;
#(
  parameter int MAX_DEPTH = 7,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beginValid,
  input  logic               endValid,
  input  logic [23:0]        endOpcode,
  input  logic [3:0]         endPrefixes,
  input  logic               featureOn,
  input  logic               abortValid,
  input  logic               commitAck,
  input  logic               commitPass,
  input  logic               rollbackAck,
  input  logic               activeQ,
  input  logic [DEPTH_W-1:0] depthQ,
  output dpStrobe_t          strb,
  output logic               commitReq,
  output logic               rollbackReq,
  output logic               faultUd,
  output logic               faultGp,
  output logic               doneQ,
  output logic [7:0]         causeQ
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(MAX_DEPTH);
  localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

  ctrlState_t state, nextState;
  logic       isEnd, udFlag, gpFlag, goAbort, doneFlag;
  logic [7:0] nextCause;

  assign isEnd = endValid && (endOpcode == END_OPCODE);

  always_comb begin
    strb      = '0;
    nextState = state;
    udFlag    = 1'b0;
    gpFlag    = 1'b0;
    goAbort   = 1'b0;
    doneFlag  = 1'b0;
    nextCause = causeQ;
    unique case (state)
      ST_RUN: begin
        if (abortValid && activeQ) begin
          goAbort   = 1'b1;
          nextCause = CAUSE_EXT;
        end else if (isEnd) begin
          if (!featureOn || (endPrefixes != 4'b0000)) begin
            udFlag = 1'b1;
          end else if (!activeQ) begin
            gpFlag = 1'b1;
          end else begin
            strb.decDepth = 1'b1;
            if (depthQ == DEPTH_ONE) nextState = ST_COMMIT;
          end
        end else if (beginValid) begin
          if (depthQ == DEPTH_MAX) begin
            goAbort   = 1'b1;
            nextCause = CAUSE_NEST;
          end else begin
            strb.incDepth      = 1'b1;
            strb.latchFallback = (depthQ == '0);
          end
        end
      end
      ST_COMMIT: begin
        if (commitAck) begin
          if (commitPass) begin
            strb.clearAll = 1'b1;
            nextState     = ST_RUN;
          end else begin
            goAbort   = 1'b1;
            nextCause = CAUSE_FAIL;
          end
        end
      end
      ST_ROLLBACK: begin
        if (rollbackAck) begin
          strb.clearAll = 1'b1;
          doneFlag      = 1'b1;
          nextState     = ST_RUN;
        end
      end
      default: nextState = ST_RUN;
    endcase
    if (goAbort) nextState = ST_ROLLBACK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      commitReq   <= 1'b0;
      rollbackReq <= 1'b0;
      faultUd     <= 1'b0;
      faultGp     <= 1'b0;
      doneQ       <= 1'b0;
      causeQ      <= '0;
    end else begin
      state       <= nextState;
      commitReq   <= (nextState == ST_COMMIT);
      rollbackReq <= (nextState == ST_ROLLBACK);
      faultUd     <= udFlag;
      faultGp     <= gpFlag;
      doneQ       <= doneFlag;
      if (goAbort) causeQ <= nextCause;
    end
  end

  p_gp_inactive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    faultGp |-> !activeQ);
  p_fault_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(faultUd && faultGp));
  p_commit_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commitReq) |-> depthQ == '0);
  p_commit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commitReq && !commitAck) |=> commitReq);
  p_rollback_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rollbackReq && !rollbackAck) |=> rollbackReq);
  p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ |-> (depthQ == '0 && !activeQ));
  p_req_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(commitReq && rollbackReq));
endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
  import txn_nest_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int MAX_DEPTH = 7,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beginValid,
  input  logic [ADDR_W-1:0]  beginFallback,
  input  logic               endValid,
  input  logic [23:0]        endOpcode,
  input  logic [3:0]         endPrefixes,
  input  logic [31:0]        featureWord,
  input  logic               abortValid,
  input  logic               longMode,
  output logic               commitReq,
  input  logic               commitAck,
  input  logic               commitPass,
  output logic               rollbackReq,
  input  logic               rollbackAck,
  output logic               statusValid,
  output logic [31:0]        statusWord,
  output logic               pcLoadValid,
  output logic [ADDR_W-1:0]  pcLoadAddr,
  output logic               faultUd,
  output logic               faultGp,
  output logic [15:0]        faultErrCode,
  output logic               active,
  output logic [DEPTH_W-1:0] nestDepth
);
  dpStrobe_t  strb;
  logic       doneQ;
  logic [7:0] causeQ;
  logic       unusedFeature;

  assign unusedFeature = ^{featureWord[31:FEATURE_BIT+1], featureWord[FEATURE_BIT-1:0]};

  txn_nest_ctrl_fsm #(.MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .beginValid(beginValid), .endValid(endValid),
    .endOpcode(endOpcode), .endPrefixes(endPrefixes),
    .featureOn(featureWord[FEATURE_BIT]), .abortValid(abortValid),
    .commitAck(commitAck), .commitPass(commitPass), .rollbackAck(rollbackAck),
    .activeQ(active), .depthQ(nestDepth), .strb(strb), .commitReq(commitReq),
    .rollbackReq(rollbackReq), .faultUd(faultUd), .faultGp(faultGp),
    .doneQ(doneQ), .causeQ(causeQ)
  );

  txn_nest_datapath #(.ADDR_W(ADDR_W), .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .beginFallback(beginFallback),
    .longMode(longMode), .activeQ(active), .depthQ(nestDepth), .pcTarget(pcLoadAddr)
  );

  assign statusValid  = doneQ;
  assign pcLoadValid  = doneQ;
  assign statusWord   = {24'h0, causeQ};
  assign faultErrCode = 16'h0000;
endmodule

// File: tb/txn_nest_ctrl_tb.sv
module txn_nest_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 64;
  localparam int MAXD = 7;
  localparam int DW = 3;
  localparam logic [23:0] OPC = 24'h0F01D5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic beginValid = 0, endValid = 0, abortValid = 0, longMode = 1;
  logic [ADDR_W-1:0] beginFallback = '0;
  logic [23:0] endOpcode = OPC;
  logic [3:0] endPrefixes = '0;
  logic [31:0] featureWord = 32'h0000_0800;
  logic commitAck = 0, commitPass = 0, rollbackAck = 0;
  logic commitReq, rollbackReq, statusValid, pcLoadValid, faultUd, faultGp, active;
  logic [31:0] statusWord;
  logic [ADDR_W-1:0] pcLoadAddr;
  logic [15:0] faultErrCode;
  logic [DW-1:0] nestDepth;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_nest_ctrl #(.ADDR_W(ADDR_W), .MAX_DEPTH(MAXD)) dut_i (.*);

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doBegin(input logic [ADDR_W-1:0] a);
    @(negedge clk); beginValid = 1; beginFallback = a;
    @(negedge clk); beginValid = 0;
  endtask

  task automatic doEnd(input logic [23:0] op, input logic [3:0] pf);
    @(negedge clk); endValid = 1; endOpcode = op; endPrefixes = pf;
    @(negedge clk); endValid = 0; endOpcode = OPC; endPrefixes = '0;
  endtask

  task automatic finishRollback(input logic [7:0] cause, input logic [ADDR_W-1:0] pc, input string tag);
    chk(rollbackReq, {tag, " rollbackReq"}, rollbackReq, 1);
    @(negedge clk);
    chk(rollbackReq && !statusValid, {tag, " hold"}, rollbackReq, 1);
    rollbackAck = 1;
    @(negedge clk); rollbackAck = 0;
    chk(statusValid && pcLoadValid, {tag, " R10 strobes"}, statusValid, 1);
    chk(statusWord[7:0] == cause, {tag, " status"}, statusWord, cause);
    chk(pcLoadAddr == pc, {tag, " pc"}, pcLoadAddr, pc);
    chk(!active && nestDepth == 0 && !rollbackReq, {tag, " R10 cleared"}, nestDepth, 0);
    @(negedge clk);
    chk(!statusValid, {tag, " pulse"}, statusValid, 0);
  endtask

  task automatic tReset();
    chk(!active && nestDepth == 0 && !commitReq && !rollbackReq, "reset", nestDepth, 0);
  endtask

  task automatic tGp();
    doEnd(OPC, 4'b0);
    chk(faultGp && !faultUd, "R3 gp", faultGp, 1);
    chk(faultErrCode == 0, "R3 errcode", faultErrCode, 0);
    chk(!active && nestDepth == 0, "R3 nochange", nestDepth, 0);
  endtask

  task automatic tUd();
    featureWord = 32'h0;
    doEnd(OPC, 4'b0);
    chk(faultUd && !faultGp, "R2 feature off priority", faultUd, 1);
    featureWord = 32'h0000_0800;
    doBegin(64'h1000);
    doEnd(OPC, 4'b1000);
    chk(faultUd && nestDepth == 1 && active, "R2 lock prefix", nestDepth, 1);
    doEnd(OPC, 4'b0001);
    chk(faultUd && nestDepth == 1, "R2 f3 prefix", nestDepth, 1);
    doEnd(24'h0F01D6, 4'b0);
    chk(!faultUd && !faultGp && nestDepth == 1 && !commitReq, "R1 wrong opcode", nestDepth, 1);
    doEnd(OPC, 4'b0);
    @(negedge clk); commitAck = 1; commitPass = 1;
    @(negedge clk); commitAck = 0;
  endtask

  task automatic tNestCommit();
    doBegin(64'hAAAA_0000_1111_2222);
    doBegin(64'hBBBB);
    doBegin(64'hCCCC);
    chk(nestDepth == 3 && active, "R4 depth", nestDepth, 3);
    doEnd(OPC, 4'b0);
    chk(nestDepth == 2 && !commitReq, "R5 inner end", nestDepth, 2);
    doEnd(OPC, 4'b0);
    doEnd(OPC, 4'b0);
    chk(nestDepth == 0 && commitReq, "R5 outer commit", commitReq, 1);
    @(negedge clk);
    chk(commitReq && active, "R6 hold", commitReq, 1);
    commitAck = 1; commitPass = 1;
    @(negedge clk); commitAck = 0;
    chk(!active && !commitReq && !pcLoadValid && !rollbackReq, "R6 pass", active, 0);
  endtask

  task automatic tCommitFail();
    doBegin(64'hAAAA_0000_1111_2222);
    doBegin(64'hDEAD);
    doEnd(OPC, 4'b0); doEnd(OPC, 4'b0);
    commitAck = 1; commitPass = 0;
    @(negedge clk); commitAck = 0;
    finishRollback(8'h02, 64'hAAAA_0000_1111_2222, "R7");
  endtask

  task automatic tAbort();
    @(negedge clk); abortValid = 1;
    @(negedge clk); abortValid = 0;
    chk(!rollbackReq && !active, "R8 inactive ignored", rollbackReq, 0);
    doBegin(64'h5555_0000_0000_0010);
    doBegin(64'h20);
    @(negedge clk); abortValid = 1;
    @(negedge clk); abortValid = 0;
    finishRollback(8'h01, 64'h5555_0000_0000_0010, "R8");
  endtask

  task automatic tOverflow();
    for (int i = 0; i < MAXD; i++) doBegin(64'h9000 + 64'(i));
    chk(nestDepth == MAXD && !rollbackReq, "R9 at max", nestDepth, MAXD);
    doBegin(64'hF00D);
    chk(nestDepth == MAXD, "R9 no exceed", nestDepth, MAXD);
    finishRollback(8'h04, 64'h9000, "R9");
  endtask

  task automatic tShortPc();
    longMode = 0;
    doBegin(64'h1234_5678_9ABC_DEF0);
    @(negedge clk); abortValid = 1;
    @(negedge clk); abortValid = 0;
    @(negedge clk); beginValid = 1; beginFallback = 64'h77;
    @(negedge clk); beginValid = 0;
    chk(nestDepth == 1 && rollbackReq, "R12 begin ignored", nestDepth, 1);
    finishRollback(8'h01, 64'h0000_0000_9ABC_DEF0, "R11");
    longMode = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tReset();
    tGp();
    tUd();
    tNestCommit();
    tCommitFail();
    tAbort();
    tOverflow();
    tShortPc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule